// File: doc/BRIEF.md
# Hub Status Change Reporter

This block holds the status-change bitmap that a hub returns on its interrupt endpoint and answers the host's IN polls on that endpoint. A hub-level change flag and one change event per downstream port feed it. Port events are kept in sticky pending bits until the host clears them through a per-port clear strobe. At the end-of-frame marker (EOF2) of every frame, the hub flag and the pending port bits are copied into a one-byte bitmap. That bitmap is the one answered during the following frame.

An IN-token strobe gets exactly one response on the next cycle. If the hub is configured and the bitmap is non-zero, the response is a payload-valid pulse carrying the whole byte. Otherwise it is a NAK pulse. Because the pending bits stay set until cleared, every poll keeps reporting a change until the host acknowledges it. The packet serializer and descriptor handling sit outside this block.

Top module: `hub_chg_reporter`

## Requirements
- R1: After reset the bitmap and all pending port bits are zero, and `rsp_valid`, `rsp_nak` and `rsp_byte` are low. A poll made before any new change is answered with NAK.
- R2: A pulse on `port_evt[i]` sets a pending bit that appears as bitmap bit i+1 only after the first `eof2_stb` edge strictly later than the pulse. A pulse in the same cycle as `eof2_stb` waits for the next marker.
- R3: Bitmap bit 0 takes the level of `hub_evt` at each `eof2_stb` edge.
- R4: Bitmap bits NPORTS+1 and above are always zero. With the defaults these are bits 5 to 7.
- R5: An IN strobe while `configured` is high and the bitmap is non-zero gives, one cycle later, `rsp_valid` high with `rsp_byte` equal to the bitmap as it stood before that edge.
- R6: An IN strobe while the bitmap is all zero gives a NAK pulse one cycle later.
- R7: An IN strobe while `configured` is low gives a NAK pulse, whatever the bitmap holds.
- R8: In the cycle after an IN strobe exactly one of `rsp_valid` and `rsp_nak` is high. In the cycle after any other edge both are low.
- R9: A reported port bit is returned on every poll until `port_clr[i]` pulses. The clear removes the bit from the next EOF2 sample but leaves the current bitmap unchanged.
- R10: When `port_evt[i]` and `port_clr[i]` pulse in the same cycle, the change wins and the pending bit stays set.
- R11: `rsp_byte` is zero whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hub_evt | input | 1 | Hub-level change flag (level) |
| port_evt | input | NPORTS | Per-port change event pulses |
| port_clr | input | NPORTS | Per-port host clear strobes |
| eof2_stb | input | 1 | End-of-frame sampling marker |
| in_stb | input | 1 | IN token for the interrupt endpoint |
| configured | input | 1 | Hub has been configured by the host |
| rsp_valid | output | 1 | Payload response pulse |
| rsp_nak | output | 1 | NAK response pulse |
| rsp_byte | output | MAP_W | Bitmap payload, valid with rsp_valid |

## Verification
The hardest situations to reach are edges where several strobes coincide. These are a change pulse landing on the EOF2 edge, a clear landing together with a fresh change, and an IN poll landing on the EOF2 edge, which must return the old bitmap. Directed steps place each of these collisions deliberately. A long seeded random run then drives all strobes with independent probabilities, so that many further coincidences occur. Each response is compared with a bench model of pending bits and bitmap that updates once per edge.

// File: rtl/hscr_pkg.sv
package hscr_pkg;
   typedef enum logic [1:0] {
      RSP_IDLE = 2'd0,
      RSP_DATA = 2'd1,
      RSP_NAK  = 2'd2
   } rsp_kind_e;
endpackage

// File: rtl/hscr_pend.sv
module hscr_pend #(
   parameter int NPORTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] chg_evt,
   input  logic [NPORTS-1:0] clr_stb,
   output logic [NPORTS-1:0] pend
);
   // One sticky bit per port; a new change outranks a simultaneous clear.
   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (!rst_n)          pend[p] <= 1'b0;
         else if (chg_evt[p]) pend[p] <= 1'b1;
         else if (clr_stb[p]) pend[p] <= 1'b0;
      end
   end
endmodule

// File: rtl/hscr_map.sv
module hscr_map #(
   parameter int NPORTS = 4,
   parameter int MAP_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              hub_flag,
   input  logic [NPORTS-1:0] pend,
   output logic [MAP_W-1:0]  map_q
);
   localparam int USED = NPORTS + 1;
   localparam int PAD  = MAP_W - USED;

   logic [MAP_W-1:0] map_d;

   if (PAD > 0) begin : g_pad
      assign map_d = {{PAD{1'b0}}, pend, hub_flag};
   end else begin : g_nopad
      assign map_d = {pend, hub_flag};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      map_q <= '0;
      else if (sample) map_q <= map_d;
   end
endmodule

// File: rtl/hscr_poll.sv
module hscr_poll
   import hscr_pkg::*;
#(
   parameter int MAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll,
   input  logic             cfg_ok,
   input  logic [MAP_W-1:0] map_q,
   output logic             rsp_valid,
   output logic             rsp_nak,
   output logic [MAP_W-1:0] rsp_byte
);
   rsp_kind_e        kind_d, kind_q;
   logic [MAP_W-1:0] byte_q;

   always_comb begin
      kind_d = RSP_IDLE;
      if (poll) kind_d = (cfg_ok && (map_q != '0)) ? RSP_DATA : RSP_NAK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= RSP_IDLE;
         byte_q <= '0;
      end else begin
         kind_q <= kind_d;
         byte_q <= (kind_d == RSP_DATA) ? map_q : '0;
      end
   end

   assign rsp_valid = (kind_q == RSP_DATA);
   assign rsp_nak   = (kind_q == RSP_NAK);
   assign rsp_byte  = byte_q;
endmodule

// File: rtl/hub_chg_reporter.sv
module hub_chg_reporter #(
   parameter int NPORTS = 4,
   parameter int MAP_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hub_evt,
   input  logic [NPORTS-1:0] port_evt,
   input  logic [NPORTS-1:0] port_clr,
   input  logic              eof2_stb,
   input  logic              in_stb,
   input  logic              configured,
   output logic              rsp_valid,
   output logic              rsp_nak,
   output logic [MAP_W-1:0]  rsp_byte
);
   if (NPORTS < 1 || MAP_W < NPORTS + 1) begin : g_bad_cfg
      $error("hub_chg_reporter: MAP_W must hold NPORTS+1 bits");
   end

   logic [NPORTS-1:0] pend;
   logic [MAP_W-1:0]  status_map;

   hscr_pend #(.NPORTS(NPORTS)) u_pend (
      .clk(clk), .rst_n(rst_n), .chg_evt(port_evt), .clr_stb(port_clr),
      .pend(pend)
   );

   hscr_map #(.NPORTS(NPORTS), .MAP_W(MAP_W)) u_map (
      .clk(clk), .rst_n(rst_n), .sample(eof2_stb), .hub_flag(hub_evt),
      .pend(pend), .map_q(status_map)
   );

   hscr_poll #(.MAP_W(MAP_W)) u_poll (
      .clk(clk), .rst_n(rst_n), .poll(in_stb), .cfg_ok(configured),
      .map_q(status_map), .rsp_valid(rsp_valid), .rsp_nak(rsp_nak),
      .rsp_byte(rsp_byte)
   );
endmodule

// File: rtl/hub_chg_reporter_chk.sv
module hub_chg_reporter_chk #(
   parameter int NPORTS = 4,
   parameter int MAP_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_stb,
   input logic             configured,
   input logic             eof2_stb,
   input logic             rsp_valid,
   input logic             rsp_nak,
   input logic [MAP_W-1:0] rsp_byte,
   input logic [MAP_W-1:0] status_map
);
   a_r8_one_response: assert property (@(posedge clk) disable iff (!rst_n)
      in_stb |=> (rsp_valid ^ rsp_nak));

   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_stb |=> (!rsp_valid && !rsp_nak));

   a_r7_unconfigured_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && !configured) |=> rsp_nak);

   a_r6_empty_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && status_map == '0) |=> rsp_nak);

   a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_byte >> (NPORTS + 1)) == '0) && ((status_map >> (NPORTS + 1)) == '0));

   a_r11_idle_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_byte == '0));

   a_r2_map_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !eof2_stb |=> $stable(status_map));

   a_r5_payload_is_map: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && configured && status_map != '0) |=> (rsp_valid && rsp_byte == $past(status_map)));
endmodule

bind hub_chg_reporter hub_chg_reporter_chk #(.NPORTS(NPORTS), .MAP_W(MAP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .configured(configured),
   .eof2_stb(eof2_stb), .rsp_valid(rsp_valid), .rsp_nak(rsp_nak),
   .rsp_byte(rsp_byte), .status_map(status_map)
);

// File: tb/hub_chg_reporter_test.sv
module hub_chg_reporter_test;
   localparam int NP = 4;
   localparam int MW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hub_evt = 1'b0;
   logic [NP-1:0] port_evt = '0;
   logic [NP-1:0] port_clr = '0;
   logic          eof2_stb = 1'b0;
   logic          in_stb = 1'b0;
   logic          configured = 1'b0;
   logic          rsp_valid, rsp_nak;
   logic [MW-1:0] rsp_byte;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   logic [NP-1:0] m_pend = '0;
   logic [MW-1:0] m_map  = '0;

   always #4 clk = ~clk;

   hub_chg_reporter #(.NPORTS(NP), .MAP_W(MW)) uut (
      .clk(clk), .rst_n(rst_n), .hub_evt(hub_evt), .port_evt(port_evt),
      .port_clr(port_clr), .eof2_stb(eof2_stb), .in_stb(in_stb),
      .configured(configured), .rsp_valid(rsp_valid), .rsp_nak(rsp_nak),
      .rsp_byte(rsp_byte)
   );

   function automatic logic [MW-1:0] next_map(input logic [MW-1:0] cur, input logic e,
                                              input logic h, input logic [NP-1:0] p);
      logic [MW-1:0] v;
      v = '0;
      v[0] = h;
      v[NP:1] = p;
      return e ? v : cur;
   endfunction

   function automatic logic [NP-1:0] next_pend(input logic [NP-1:0] cur,
                                               input logic [NP-1:0] chg, input logic [NP-1:0] clr);
      return (cur & ~clr) | chg;
   endfunction

   task automatic check(input string req, input logic [MW+1:0] act, input logic [MW+1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual {vld,nak,byte}=%h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic h, input logic [NP-1:0] pe, input logic [NP-1:0] pc,
                       input logic e, input logic i, input logic c, input string tag);
      logic [MW+1:0] exp;
      string req;
      @(negedge clk);
      hub_evt = h; port_evt = pe; port_clr = pc; eof2_stb = e; in_stb = i; configured = c;
      @(posedge clk);
      if (!i) begin
         exp = '0; req = "R8";
      end else if (c && m_map != '0) begin
         exp = {2'b10, m_map}; req = "R5";
      end else begin
         exp = {2'b01, {MW{1'b0}}}; req = c ? "R6" : "R7";
      end
      if (tag != "") req = tag;
      m_map  = next_map(m_map, e, h, m_pend);
      m_pend = next_pend(m_pend, pe, pc);
      #1;
      check(req, {rsp_valid, rsp_nak, rsp_byte}, exp);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1157));
      repeat (3) @(posedge clk);
      #1;
      check("R1", {rsp_valid, rsp_nak, rsp_byte}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: fresh state answers NAK
      step(0, 4'h0, 4'h0, 0, 1, 1, "R1");
      step(0, 4'h0, 4'h0, 1, 0, 1, "");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R1");
      // R2: port 1 event, not yet sampled
      step(0, 4'h2, 4'h0, 0, 0, 1, "");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R2");
      step(0, 4'h0, 4'h0, 1, 0, 1, "");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R2");
      // R2: event on the EOF2 edge waits a frame
      step(0, 4'h4, 4'h0, 1, 0, 1, "");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R2");
      step(0, 4'h0, 4'h0, 1, 0, 1, "");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R2");
      // R9: clear keeps current map, drops from next sample
      step(0, 4'h0, 4'h2, 0, 1, 1, "R9");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R9");
      step(0, 4'h0, 4'h0, 1, 0, 1, "");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R9");
      // R10: change and clear together
      step(0, 4'h1, 4'h1, 0, 0, 1, "");
      step(0, 4'h0, 4'h0, 1, 0, 1, "");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R10");
      // R3: hub flag into bit 0
      step(1, 4'h0, 4'h0, 1, 0, 1, "");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R3");
      // R7: unconfigured with non-zero map
      step(0, 4'h0, 4'h0, 0, 1, 0, "R7");
      // R5: poll on the EOF2 edge sees the old map
      step(0, 4'h0, 4'hF, 0, 0, 1, "");
      step(0, 4'h0, 4'h0, 1, 1, 1, "R5");
      step(0, 4'h0, 4'h0, 0, 1, 1, "R6");
      // R4/R11 and everything else: seeded random
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 4) == 0, NP'($urandom) & NP'($urandom) & NP'($urandom),
              NP'($urandom) & NP'($urandom), ($urandom % 6) == 0,
              ($urandom % 2) == 0, ($urandom % 8) != 0, "");
      end
      step(0, 4'h0, 4'h0, 0, 0, 1, "R8");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule